// File: doc/BRIEF.md
# Multichannel Bit Interleaver and I/Q Level Formatter

This block merges up to three synchronous serial data channels into one aggregate bit stream and cuts that stream into symbols for a quadrature modulator. Each symbol yields one level code for the in-phase rail and one for the quadrature rail. In high-rate operation each rail carries three bits, which gives 8 levels. In low-rate operation each rail carries two bits, which gives 4 levels.

The block runs on one system clock and is paced by a reference clock enable, `ref_tick`. An internal prescaler divides the reference enables by a ratio that depends on the operating mode, and each division step takes one aggregate bit. The ratio is 20 for high rate, 30 for low rate with a pre-aggregated input and 60 for low rate with internal interleaving.

In internal multiplexing the block pulls bits from the active channels in turn. In external multiplexing it takes one channel that already carries the combined stream. A one-hot take strobe tells each channel source when its current bit has been consumed, so the source can present the next one.

Top module: `iq_sym_mux`

## Requirements
- R1: While `rst_n` is low, `sym_stb`, `i_lvl`, `q_lvl` and `ch_take` are all zero.
- R2: An aggregate bit is taken on every Nth `ref_tick`, counting from reset. N is 20 when `hi_rate`=1, 30 when `hi_rate`=0 and `ext_mux`=1, and 60 when `hi_rate`=0 and `ext_mux`=0.
- R3: With `ext_mux`=0, bits are taken from channels 0, 1, …, `n_act`-1 in rotation, starting with channel 0 after reset. `ch_take[k]` is high for exactly the one cycle in which channel k's `ch_data[k]` is sampled.
- R4: With `ext_mux`=1, only channel 0 is ever taken.
- R5: `sym_stb` is a one-cycle pulse. It rises in the cycle after the 6th bit of a symbol is taken (high rate) or the 4th bit (low rate).
- R6: In each symbol, the first half of the bits, in arrival order and MSB first, forms the I group, and the second half forms the Q group. Each rail's output code is the level index L whose Gray code L^(L>>1) equals that group.
- R7: `i_lvl` and `q_lvl` change only in cycles where `sym_stb` is high. In low rate, bit 2 of both codes is 0.
- R8: `cfg_err` is high when `n_act` is 0, or when it exceeds the limit for the mode: 3 for high-rate internal, 2 for low-rate internal, 1 for external. While `cfg_err` is high, `ch_take` stays zero and each symbol carries level code 0 on both rails at the normal symbol rate.
- R9: A cycle with `ref_tick` low advances nothing: no bit is taken and the prescaler holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference clock enable that paces the prescaler |
| hi_rate | input | 1 | 1 selects 8-level (3 bits per rail), 0 selects 4-level |
| ext_mux | input | 1 | 1 selects a single pre-aggregated input on channel 0 |
| n_act | input | 2 | Number of active channels |
| ch_data | input | 3 | Current bit presented by each channel |
| ch_take | output | 3 | One-hot strobe marking which channel's bit is consumed |
| cfg_err | output | 1 | Configuration not allowed for the selected mode |
| sym_stb | output | 1 | One-cycle symbol strobe, aligned with new level codes |
| i_lvl | output | 3 | In-phase level index |
| q_lvl | output | 3 | Quadrature level index |

## Verification
The bench steps a behavioural model in lockstep with the design and compares every output on every cycle. It runs each legal mode and channel count, plus three illegal settings, while `ref_tick` is randomly thinned and sometimes held low for long stretches. These runs target the following failure modes:
- A prescaler with the wrong ratio for a mode moves the take strobes off their expected cycles.
- A rotation that wraps at the wrong channel count, or that does not start at channel 0, takes from the wrong channel.
- Swapping the I and Q halves, or applying Gray encoding where decoding is needed, yields wrong level codes.
- A rate-dependent bit counter that is off by one misaligns every symbol.
- Missing error gating lets channel data leak into symbols that should be idle.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

  // Combined operating mode, decoded once and shared by the submodules.
  typedef enum logic [1:0] {
    M_HI_INT = 2'd0,
    M_HI_EXT = 2'd1,
    M_LO_INT = 2'd2,
    M_LO_EXT = 2'd3
  } iqm_mode_e;

  function automatic iqm_mode_e iqm_mode(input logic hi, input logic ext);
    if (hi) return ext ? M_HI_EXT : M_HI_INT;
    else    return ext ? M_LO_EXT : M_LO_INT;
  endfunction

endpackage

// File: rtl/iqm_prescale.sv
module iqm_prescale
  import iqm_pkg::*;
#(
  parameter int DIV_HI     = 20,
  parameter int DIV_LO_EXT = 30,
  parameter int DIV_LO_INT = 60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_tick,
  input  iqm_mode_e mode,
  output logic      bit_tick
);
  localparam int DMAX = (DIV_HI > DIV_LO_EXT)
                      ? ((DIV_HI > DIV_LO_INT) ? DIV_HI : DIV_LO_INT)
                      : ((DIV_LO_EXT > DIV_LO_INT) ? DIV_LO_EXT : DIV_LO_INT);
  localparam int CW = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, div_m1;

  always_comb begin
    unique case (mode)
      M_HI_INT, M_HI_EXT: div_m1 = CW'(DIV_HI - 1);
      M_LO_EXT:           div_m1 = CW'(DIV_LO_EXT - 1);
      default:            div_m1 = CW'(DIV_LO_INT - 1);
    endcase
  end

  always_comb begin
    cnt_d    = cnt_q;
    bit_tick = 1'b0;
    if (ref_tick) begin
      if (cnt_q == div_m1) begin
        cnt_d    = '0;
        bit_tick = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the count never passes the ratio chosen for the mode.
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_m1);

  // R9: without a reference enable the count holds.
  a_r9_hold_no_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(cnt_q));

endmodule

// File: rtl/iqm_chan_sel.sv
module iqm_chan_sel
  import iqm_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int LO_MAX = 2,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  iqm_mode_e        mode,
  input  logic [CNT_W-1:0] n_act,
  input  logic [NCH-1:0]   ch_data,
  output logic [NCH-1:0]   take,
  output logic             sel_bit,
  output logic             cfg_err
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IW-1:0]    rr_q, rr_d;
  logic [CNT_W-1:0] n_max, n_last;

  always_comb begin
    unique case (mode)
      M_HI_INT: n_max = CNT_W'(NCH);
      M_LO_INT: n_max = CNT_W'(LO_MAX);
      default:  n_max = CNT_W'(1);
    endcase
    cfg_err = (n_act == '0) || (n_act > n_max);
    n_last  = n_act - 1'b1;
  end

  always_comb begin
    rr_d = rr_q;
    if (bit_tick && !cfg_err)
      rr_d = (rr_q == IW'(n_last)) ? '0 : rr_q + 1'b1;
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (!cfg_err && rr_q == IW'(k)) sel_bit = ch_data[k];
  end

  for (genvar k = 0; k < NCH; k++) begin : g_take
    assign take[k] = bit_tick && !cfg_err && (rr_q == IW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R3: at most one channel is consumed per cycle.
  a_r3_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R4: an external stream only ever uses channel 0.
  a_r4_ext_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_HI_EXT || mode == M_LO_EXT) && (take != '0)) |-> take[0]);

  // R8: a bad configuration consumes nothing.
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (take == '0));

endmodule

// File: rtl/iqm_sym_pack.sv
module iqm_sym_pack
  import iqm_pkg::*;
#(
  parameter int RAIL_HI = 3,
  parameter int RAIL_LO = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               bit_in,
  input  iqm_mode_e          mode,
  output logic               sym_stb,
  output logic [RAIL_HI-1:0] i_lvl,
  output logic [RAIL_HI-1:0] q_lvl
);
  localparam int SW = 2 * RAIL_HI;
  localparam int BW = $clog2(SW);

  logic              hi;
  logic [SW-1:0]     sr_q, sr_d, nvec;
  logic [BW-1:0]     bc_q, bc_d, bps_m1;
  logic              stb_d;
  logic [RAIL_HI-1:0] ig, qg, ib, qb, i_d, q_d;

  assign hi     = (mode == M_HI_INT) || (mode == M_HI_EXT);
  assign bps_m1 = hi ? BW'(2 * RAIL_HI - 1) : BW'(2 * RAIL_LO - 1);
  assign nvec   = {sr_q[SW-2:0], bit_in};

  // Split the finished symbol: the earlier bits go to I, the later bits to Q.
  always_comb begin
    if (hi) begin
      ig = nvec[SW-1 -: RAIL_HI];
      qg = nvec[RAIL_HI-1:0];
    end else begin
      ig = {{(RAIL_HI-RAIL_LO){1'b0}}, nvec[2*RAIL_LO-1 -: RAIL_LO]};
      qg = {{(RAIL_HI-RAIL_LO){1'b0}}, nvec[RAIL_LO-1:0]};
    end
  end

  // Gray to level index.
  always_comb begin
    ib[RAIL_HI-1] = ig[RAIL_HI-1];
    qb[RAIL_HI-1] = qg[RAIL_HI-1];
    for (int k = RAIL_HI - 2; k >= 0; k--) begin
      ib[k] = ib[k+1] ^ ig[k];
      qb[k] = qb[k+1] ^ qg[k];
    end
  end

  always_comb begin
    sr_d  = sr_q;
    bc_d  = bc_q;
    stb_d = 1'b0;
    i_d   = i_lvl;
    q_d   = q_lvl;
    if (bit_tick) begin
      sr_d = nvec;
      if (bc_q == bps_m1) begin
        bc_d  = '0;
        stb_d = 1'b1;
        i_d   = ib;
        q_d   = qb;
      end else begin
        bc_d = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      bc_q    <= '0;
      sym_stb <= 1'b0;
      i_lvl   <= '0;
      q_lvl   <= '0;
    end else begin
      sr_q    <= sr_d;
      bc_q    <= bc_d;
      sym_stb <= stb_d;
      i_lvl   <= i_d;
      q_lvl   <= q_d;
    end
  end

  // R5: the symbol strobe never lasts two cycles.
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);

  // R7: level codes move only together with the strobe.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |-> ($stable(i_lvl) && $stable(q_lvl)));

  // R7: 4-level symbols leave the top code bit clear.
  a_r7_lo_top: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !hi) |-> (!i_lvl[RAIL_HI-1] && !q_lvl[RAIL_HI-1]));

endmodule

// File: rtl/iq_sym_mux.sv
module iq_sym_mux
  import iqm_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int LO_MAX     = 2,
  parameter int RAIL_HI    = 3,
  parameter int RAIL_LO    = 2,
  parameter int DIV_HI     = 20,
  parameter int DIV_LO_EXT = 30,
  parameter int DIV_LO_INT = 60,
  localparam int CNT_W     = $clog2(NCH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               hi_rate,
  input  logic               ext_mux,
  input  logic [CNT_W-1:0]   n_act,
  input  logic [NCH-1:0]     ch_data,
  output logic [NCH-1:0]     ch_take,
  output logic               cfg_err,
  output logic               sym_stb,
  output logic [RAIL_HI-1:0] i_lvl,
  output logic [RAIL_HI-1:0] q_lvl
);
  iqm_mode_e mode;
  logic      bit_tick;
  logic      sel_bit;

  assign mode = iqm_mode(hi_rate, ext_mux);

  iqm_prescale #(
    .DIV_HI(DIV_HI), .DIV_LO_EXT(DIV_LO_EXT), .DIV_LO_INT(DIV_LO_INT)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mode(mode),
    .bit_tick(bit_tick)
  );

  iqm_chan_sel #(.NCH(NCH), .LO_MAX(LO_MAX), .CNT_W(CNT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode(mode),
    .n_act(n_act), .ch_data(ch_data), .take(ch_take),
    .sel_bit(sel_bit), .cfg_err(cfg_err)
  );

  iqm_sym_pack #(.RAIL_HI(RAIL_HI), .RAIL_LO(RAIL_LO)) u_pack (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_in(sel_bit),
    .mode(mode), .sym_stb(sym_stb), .i_lvl(i_lvl), .q_lvl(q_lvl)
  );

  // R9: no channel is consumed in a cycle without a reference enable.
  a_r9_take_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_take != '0) |-> ref_tick);

endmodule

// File: tb/iq_sym_mux_tb_top.sv
`timescale 1ns/1ps
module iq_sym_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick;
  logic       hi_rate, ext_mux;
  logic [1:0] n_act;
  logic [2:0] ch_data;
  logic [2:0] ch_take;
  logic       cfg_err, sym_stb;
  logic [2:0] i_lvl, q_lvl;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  iq_sym_mux dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hi_rate(hi_rate),
    .ext_mux(ext_mux), .n_act(n_act), .ch_data(ch_data),
    .ch_take(ch_take), .cfg_err(cfg_err), .sym_stb(sym_stb),
    .i_lvl(i_lvl), .q_lvl(q_lvl)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int gray_level(int bits, int w);
    for (int l = 0; l < (1 << w); l++)
      if ((l ^ (l >> 1)) == bits) return l;
    return -1;
  endfunction

  task automatic run_cfg(bit hi, bit ext, int n, int cycles);
    int  pc, rr, div, bps, lim, e_stb, e_i, e_q, e_take, w;
    bit  err, tick, b;
    bit  q_bits[$];
    hi_rate = hi; ext_mux = ext; n_act = 2'(n);
    rst_n = 1'b0; ref_tick = 1'b0; ch_data = 3'b000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sym_stb", sym_stb, 0);
    chk("R1 i_lvl", i_lvl, 0);
    chk("R1 q_lvl", q_lvl, 0);
    chk("R1 ch_take", ch_take, 0);
    rst_n = 1'b1;
    div = hi ? 20 : (ext ? 30 : 60);
    bps = hi ? 6 : 4;
    w   = hi ? 3 : 2;
    lim = ext ? 1 : (hi ? 3 : 2);
    err = (n == 0) || (n > lim);
    pc = 0; rr = 0; e_stb = 0; e_i = 0; e_q = 0;
    q_bits.delete();
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ref_tick = (((c / 150) % 6) == 5) ? 1'b0 : (($urandom % 4) != 0);
      ch_data  = 3'($urandom);
      #1;
      tick   = ref_tick && (pc == div - 1);
      e_take = (tick && !err) ? (1 << rr) : 0;
      chk("R8 cfg_err", cfg_err, err);
      if (err)           chk("R8 ch_take", ch_take, e_take);
      else if (!ref_tick) chk("R9 ch_take", ch_take, e_take);
      else if (ext)      chk("R2 R4 ch_take", ch_take, e_take);
      else               chk("R2 R3 ch_take", ch_take, e_take);
      chk("R5 sym_stb", sym_stb, e_stb);
      chk("R6 R7 i_lvl", i_lvl, e_i);
      chk("R6 R7 q_lvl", q_lvl, e_q);
      // advance model
      e_stb = 0;
      if (ref_tick) pc = tick ? 0 : pc + 1;
      if (tick) begin
        b = err ? 1'b0 : ch_data[rr];
        q_bits.push_back(b);
        if (!err) rr = (rr + 1) % n;
        if (q_bits.size() == bps) begin
          int ig = 0, qg = 0;
          for (int k = 0; k < w; k++) ig = (ig << 1) | q_bits[k];
          for (int k = w; k < 2 * w; k++) qg = (qg << 1) | q_bits[k];
          e_i = gray_level(ig, w);
          e_q = gray_level(qg, w);
          e_stb = 1;
          q_bits.delete();
        end
      end
    end
  endtask

  initial begin
    #1500us;
    n_err++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    run_cfg(1, 0, 3, 2000);  // R3 three channels
    run_cfg(1, 0, 2, 1500);
    run_cfg(1, 0, 1, 1500);
    run_cfg(1, 1, 1, 1500);  // R4
    run_cfg(0, 0, 2, 2500);  // R2 ratio 60
    run_cfg(0, 0, 1, 2000);
    run_cfg(0, 1, 1, 1500);  // R2 ratio 30
    run_cfg(1, 0, 0, 1000);  // R8 zero channels
    run_cfg(0, 0, 3, 1500);  // R8 too many for low rate
    run_cfg(1, 1, 2, 1000);  // R8 external with two
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule